// File: doc/BRIEF.md
# Banked CPU Register File

This block is the general-purpose register store of a small 16-bit processor core. It keeps four data registers, two address registers and a frame base register in two complete copies. A bank bit in the flag word picks the copy that every access reaches. Alongside the banked set sit two stack pointers, a static base register and the flag word itself. Only one stack pointer is visible at a time, chosen by a stack-select flag bit.

Two combinational read ports and one clocked write port each carry a 4-bit register selector and a 2-bit size field. The size field gives byte, word or 32-bit pair access. A separate flag-update input lets an execution unit refresh the arithmetic condition bits in the same cycle as an ordinary register write. Decode, ALU and program flow live outside this block.

Top module: `banked_regfile`

## Requirements
- R1: Data registers 0–3, address registers 0–1 and the frame base exist in two copies. Flag bit 4 (0 = copy 0, 1 = copy 1) selects the copy that reads and writes reach. A write never alters the copy that is not selected.
- R2: Data registers 0 and 1 accept byte accesses. Size 0 is the low byte (bits 7:0) and size 1 is the high byte (bits 15:8). A byte write takes its value from write data bits 7:0 and leaves the other byte unchanged. A byte read returns the byte in bits 7:0 with all other bits 0.
- R3: Size 3 with selector 0 accesses the 32-bit pair {data 2, data 0}, and with selector 1 the pair {data 3, data 1}, the upper register in bits 31:16. A pair write updates both halves on the same clock edge.
- R4: Selector 7 reaches the interrupt stack pointer when flag bit 7 is 0 and the user stack pointer when it is 1. A write changes only the pointer selected at that moment.
- R5: Flag bit positions are: 0 carry, 1 debug, 2 zero, 3 sign, 4 bank select, 5 overflow, 6 interrupt enable, 7 stack select, 14:12 priority level. Bits 11:8 and 15 always read 0, whatever was written.
- R6: Selector codes: 0–3 data registers, 4–5 address registers, 6 frame base, 7 stack pointer, 8 static base, 9 flags. Size 2 is a word access, and a word read is zero-extended to 32 bits.
- R7: Selectors 10–15, byte sizes on selectors other than 0 and 1, and size 3 on selectors other than 0 and 1 are invalid. Such a write changes no register, and such a read returns 0.
- R8: Reads are combinational and writes take effect on the rising edge. After a write that changes the bank or stack-select bit, reads from the next cycle on see the newly selected registers.
- R9: A synchronous reset clears every register in both banks. After reset, bank 0 and the interrupt stack pointer are selected.
- R10: While the flag-update input is high, the carry, zero, sign and overflow bits load from their dedicated inputs and the other flag bits are kept. A word write to selector 9 in the same cycle takes full precedence.
- R11: The two read ports decode independently and may address any registers and sizes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write port enable |
| wrSel | input | 4 | Write register selector |
| wrSize | input | 2 | Write access size |
| wrData | input | 32 | Write data |
| flagUpdEn | input | 1 | Condition-bit update enable |
| flagCarry | input | 1 | New carry bit |
| flagZero | input | 1 | New zero bit |
| flagSign | input | 1 | New sign bit |
| flagOvf | input | 1 | New overflow bit |
| rdSelA | input | 4 | Read port A selector |
| rdSizeA | input | 2 | Read port A size |
| rdDataA | output | 32 | Read port A data |
| rdSelB | input | 4 | Read port B selector |
| rdSizeB | input | 2 | Read port B size |
| rdDataB | output | 32 | Read port B data |

## Verification
Two updates can fall on the flag word in the same cycle: a general write to selector 9 and the condition-bit update. A write that flips the bank or stack bit can also coincide with condition updates, which changes where the next cycle's accesses land. The random phase enables both update paths independently on every cycle. Directed steps force a flag write and a flag update together with conflicting values. The bench model applies the stated precedence and reads the selected bank from the pre-edge flag value. Both read ports then expose the outcome on the following cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NUM_BANKS = 2;
  localparam int NUM_DATA  = 4;
  localparam int NUM_ADDR  = 2;

  typedef enum logic [3:0] {
    SEL_D0  = 4'd0, SEL_D1 = 4'd1, SEL_D2 = 4'd2, SEL_D3 = 4'd3,
    SEL_A0  = 4'd4, SEL_A1 = 4'd5, SEL_FB = 4'd6, SEL_SP = 4'd7,
    SEL_SB  = 4'd8, SEL_FLG = 4'd9
  } regSel_e;

  typedef enum logic [1:0] {
    SZ_BLO = 2'd0, SZ_BHI = 2'd1, SZ_WORD = 2'd2, SZ_LONG = 2'd3
  } accSize_e;

  localparam int FLG_C    = 0;
  localparam int FLG_D    = 1;
  localparam int FLG_Z    = 2;
  localparam int FLG_S    = 3;
  localparam int FLG_BANK = 4;
  localparam int FLG_O    = 5;
  localparam int FLG_I    = 6;
  localparam int FLG_SPU  = 7;
  localparam logic [15:0] FLG_MASK = 16'h70FF;

  typedef struct packed {
    logic [NUM_DATA-1:0] dLo;
    logic [NUM_DATA-1:0] dHi;
    logic                byteHiSrc;
    logic                longWr;
    logic [NUM_ADDR-1:0] aWe;
    logic                fbWe;
    logic                uspWe;
    logic                ispWe;
    logic                sbWe;
    logic                flgWe;
    logic                flgUpd;
  } wrStrobe_t;

  function automatic logic accessOk(input logic [3:0] sel, input logic [1:0] size);
    logic ok;
    if (sel > 4'd9) ok = 1'b0;
    else if (size == 2'd2) ok = 1'b1;
    else ok = (sel <= 4'd1);
    return ok;
  endfunction
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
(
  input  logic       wrEn,
  input  logic [3:0] wrSel,
  input  logic [1:0] wrSize,
  input  logic       flagUpdEn,
  input  logic       spUser,
  output wrStrobe_t  wrStb
);
  regSel_e  selE;
  accSize_e sizeE;
  logic     wrOk;

  assign selE  = regSel_e'(wrSel);
  assign sizeE = accSize_e'(wrSize);
  assign wrOk  = wrEn && accessOk(wrSel, wrSize);

  always_comb begin
    wrStb        = '0;
    wrStb.flgUpd = flagUpdEn;
    if (wrOk) begin
      case (selE)
        SEL_D0, SEL_D1, SEL_D2, SEL_D3: begin
          case (sizeE)
            SZ_BLO: wrStb.dLo[wrSel[1:0]] = 1'b1;
            SZ_BHI: begin
              wrStb.dHi[wrSel[1:0]] = 1'b1;
              wrStb.byteHiSrc       = 1'b1;
            end
            SZ_WORD: begin
              wrStb.dLo[wrSel[1:0]] = 1'b1;
              wrStb.dHi[wrSel[1:0]] = 1'b1;
            end
            SZ_LONG: begin
              wrStb.dLo[wrSel[1:0]]        = 1'b1;
              wrStb.dHi[wrSel[1:0]]        = 1'b1;
              wrStb.dLo[{1'b1, wrSel[0]}]  = 1'b1;
              wrStb.dHi[{1'b1, wrSel[0]}]  = 1'b1;
              wrStb.longWr                 = 1'b1;
            end
            default: ;
          endcase
        end
        SEL_A0:  wrStb.aWe[0] = 1'b1;
        SEL_A1:  wrStb.aWe[1] = 1'b1;
        SEL_FB:  wrStb.fbWe   = 1'b1;
        SEL_SP: begin
          wrStb.uspWe = spUser;
          wrStb.ispWe = !spUser;
        end
        SEL_SB:  wrStb.sbWe   = 1'b1;
        SEL_FLG: wrStb.flgWe  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  wrStrobe_t                wrStb,
  input  logic [2*DATA_W-1:0]      wrData,
  input  logic [3:0]               flgBits,
  input  logic [1:0][3:0]          rdSel,
  input  logic [1:0][1:0]          rdSize,
  output logic [1:0][2*DATA_W-1:0] rdData,
  output logic [DATA_W-1:0]        flagQ
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int LONG_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] FMASK = DATA_W'(FLG_MASK);

  logic [NUM_BANKS-1:0][NUM_DATA-1:0][DATA_W-1:0] dAll;
  logic [NUM_BANKS-1:0][NUM_ADDR-1:0][DATA_W-1:0] aAll;
  logic [NUM_BANKS-1:0][DATA_W-1:0]               fbAll;
  logic [NUM_DATA-1:0][DATA_W-1:0]                dCur;
  logic [NUM_ADDR-1:0][DATA_W-1:0]                aCur;
  logic [DATA_W-1:0] fbCur, uspQ, ispQ, sbQ, spCur;
  logic              bankSel;

  assign bankSel = flagQ[FLG_BANK];
  assign dCur    = dAll[bankSel];
  assign aCur    = aAll[bankSel];
  assign fbCur   = fbAll[bankSel];
  assign spCur   = flagQ[FLG_SPU] ? uspQ : ispQ;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic here;
    assign here = (int'(bankSel) == b);

    for (genvar i = 0; i < NUM_DATA; i++) begin : g_data
      localparam bit UPPER = (i >= 2);
      logic [DATA_W-1:0] q, src;
      logic [BYTE_W-1:0] hiVal;
      assign src   = (UPPER && wrStb.longWr) ? wrData[LONG_W-1:DATA_W] : wrData[DATA_W-1:0];
      assign hiVal = wrStb.byteHiSrc ? wrData[BYTE_W-1:0] : src[DATA_W-1:BYTE_W];
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (here) begin
          if (wrStb.dLo[i]) q[BYTE_W-1:0]      <= src[BYTE_W-1:0];
          if (wrStb.dHi[i]) q[DATA_W-1:BYTE_W] <= hiVal;
        end
      end
      assign dAll[b][i] = q;
    end

    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_addr
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (here && wrStb.aWe[i]) q <= wrData[DATA_W-1:0];
      end
      assign aAll[b][i] = q;
    end

    logic [DATA_W-1:0] fbQ;
    always_ff @(posedge clk) begin
      if (rst) fbQ <= '0;
      else if (here && wrStb.fbWe) fbQ <= wrData[DATA_W-1:0];
    end
    assign fbAll[b] = fbQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uspQ <= '0;
      ispQ <= '0;
      sbQ  <= '0;
    end else begin
      if (wrStb.uspWe) uspQ <= wrData[DATA_W-1:0];
      if (wrStb.ispWe) ispQ <= wrData[DATA_W-1:0];
      if (wrStb.sbWe)  sbQ  <= wrData[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flagQ <= '0;
    else if (wrStb.flgWe) flagQ <= wrData[DATA_W-1:0] & FMASK;
    else if (wrStb.flgUpd) begin
      flagQ[FLG_C] <= flgBits[0];
      flagQ[FLG_Z] <= flgBits[1];
      flagQ[FLG_S] <= flgBits[2];
      flagQ[FLG_O] <= flgBits[3];
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    regSel_e  selE;
    accSize_e sizeE;
    logic [DATA_W-1:0] word;
    assign selE  = regSel_e'(rdSel[p]);
    assign sizeE = accSize_e'(rdSize[p]);

    always_comb begin
      case (selE)
        SEL_D0, SEL_D1, SEL_D2, SEL_D3: word = dCur[rdSel[p][1:0]];
        SEL_A0:  word = aCur[0];
        SEL_A1:  word = aCur[1];
        SEL_FB:  word = fbCur;
        SEL_SP:  word = spCur;
        SEL_SB:  word = sbQ;
        SEL_FLG: word = flagQ;
        default: word = '0;
      endcase
    end

    always_comb begin
      rdData[p] = '0;
      if (accessOk(rdSel[p], rdSize[p])) begin
        case (sizeE)
          SZ_BLO:  rdData[p] = LONG_W'(word[BYTE_W-1:0]);
          SZ_BHI:  rdData[p] = LONG_W'(word[DATA_W-1:BYTE_W]);
          SZ_WORD: rdData[p] = LONG_W'(word);
          SZ_LONG: rdData[p] = {dCur[{1'b1, rdSel[p][0]}], word};
          default: rdData[p] = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wrEn,
  input  logic [3:0]          wrSel,
  input  logic [1:0]          wrSize,
  input  logic [2*DATA_W-1:0] wrData,
  input  logic                flagUpdEn,
  input  logic                flagCarry,
  input  logic                flagZero,
  input  logic                flagSign,
  input  logic                flagOvf,
  input  logic [3:0]          rdSelA,
  input  logic [1:0]          rdSizeA,
  output logic [2*DATA_W-1:0] rdDataA,
  input  logic [3:0]          rdSelB,
  input  logic [1:0]          rdSizeB,
  output logic [2*DATA_W-1:0] rdDataB
);
  wrStrobe_t                wrStb;
  logic [DATA_W-1:0]        flagQ;
  logic [1:0][2*DATA_W-1:0] rdBus;

  rf_ctrl u_ctrl (
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrSize    (wrSize),
    .flagUpdEn (flagUpdEn),
    .spUser    (flagQ[FLG_SPU]),
    .wrStb     (wrStb)
  );

  rf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .wrStb   (wrStb),
    .wrData  (wrData),
    .flgBits ({flagOvf, flagSign, flagZero, flagCarry}),
    .rdSel   ({rdSelB, rdSelA}),
    .rdSize  ({rdSizeB, rdSizeA}),
    .rdData  (rdBus),
    .flagQ   (flagQ)
  );

  assign rdDataA = rdBus[0];
  assign rdDataB = rdBus[1];
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
  import rf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                wrEn,
  input logic [3:0]          wrSel,
  input logic [1:0]          wrSize,
  input logic [2*DATA_W-1:0] wrData,
  input logic                flagUpdEn,
  input logic [3:0]          rdSelA,
  input logic [1:0]          rdSizeA,
  input logic [2*DATA_W-1:0] rdDataA,
  input logic [DATA_W-1:0]   flagQ,
  input wrStrobe_t           wrStb
);
  localparam logic [DATA_W-1:0] FMASK = DATA_W'(FLG_MASK);

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (flagQ == '0));

  p_reserved_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (flagQ & ~FMASK) == '0);

  p_one_stack_r4: assert property (@(posedge clk) disable iff (rst)
    !(wrStb.uspWe && wrStb.ispWe) && (!wrStb.uspWe || flagQ[FLG_SPU])
    && (!wrStb.ispWe || !flagQ[FLG_SPU]));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrSel == 4'd9 && wrSize == 2'd2)
    |=> (flagQ == ($past(wrData[DATA_W-1:0]) & FMASK)));

  p_bad_write_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !accessOk(wrSel, wrSize) && !flagUpdEn) |=> $stable(flagQ));

  p_bad_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !accessOk(rdSelA, rdSizeA) |-> (rdDataA == '0));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrSize(wrSize),
  .wrData(wrData), .flagUpdEn(flagUpdEn), .rdSelA(rdSelA), .rdSizeA(rdSizeA),
  .rdDataA(rdDataA), .flagQ(flagQ), .wrStb(wrStb)
);

// File: tb/sim_banked_regfile.sv
module sim_banked_regfile;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MASK = 16'h70FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [1:0]  wrSize = '0;
  logic [31:0] wrData = '0;
  logic        flagUpdEn = 1'b0, flagCarry = 1'b0, flagZero = 1'b0, flagSign = 1'b0, flagOvf = 1'b0;
  logic [3:0]  rdSelA = '0, rdSelB = '0;
  logic [1:0]  rdSizeA = '0, rdSizeB = '0;
  logic [31:0] rdDataA, rdDataB;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] mD [2][4];
  logic [15:0] mA [2][2];
  logic [15:0] mFb [2];
  logic [15:0] mUsp, mIsp, mSb, mFlg;

  banked_regfile u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrSize(wrSize), .wrData(wrData),
    .flagUpdEn(flagUpdEn), .flagCarry(flagCarry), .flagZero(flagZero), .flagSign(flagSign),
    .flagOvf(flagOvf), .rdSelA(rdSelA), .rdSizeA(rdSizeA), .rdDataA(rdDataA),
    .rdSelB(rdSelB), .rdSizeB(rdSizeB), .rdDataB(rdDataB)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit legal(input logic [3:0] s, input logic [1:0] z);
    if (s > 4'd9) return 1'b0;
    if (z == 2'd2) return 1'b1;
    return s <= 4'd1;
  endfunction

  function automatic string reqOf(input logic [3:0] s, input logic [1:0] z);
    if (!legal(s, z)) return "R7";
    if (z == 2'd3) return "R3";
    if (z != 2'd2) return "R2";
    if (s == 4'd7) return "R4";
    if (s == 4'd9) return "R5";
    if (s <= 4'd6) return "R1";
    return "R6";
  endfunction

  function automatic logic [31:0] expRead(input logic [3:0] s, input logic [1:0] z);
    logic [15:0] w;
    logic b;
    b = mFlg[4];
    if (!legal(s, z)) return '0;
    case (s)
      4'd0, 4'd1, 4'd2, 4'd3: w = mD[b][s[1:0]];
      4'd4: w = mA[b][0];
      4'd5: w = mA[b][1];
      4'd6: w = mFb[b];
      4'd7: w = mFlg[7] ? mUsp : mIsp;
      4'd8: w = mSb;
      default: w = mFlg;
    endcase
    case (z)
      2'd0: return {24'd0, w[7:0]};
      2'd1: return {24'd0, w[15:8]};
      2'd2: return {16'd0, w};
      default: return {mD[b][{1'b1, s[0]}], w};
    endcase
  endfunction

  task automatic modelWrite();
    logic b;
    logic [15:0] nf;
    b  = mFlg[4];
    nf = mFlg;
    if (flagUpdEn) begin
      nf[0] = flagCarry; nf[2] = flagZero; nf[3] = flagSign; nf[5] = flagOvf;
    end
    if (wrEn && legal(wrSel, wrSize)) begin
      case (wrSel)
        4'd0, 4'd1, 4'd2, 4'd3: begin
          case (wrSize)
            2'd0: mD[b][wrSel[1:0]][7:0]  = wrData[7:0];
            2'd1: mD[b][wrSel[1:0]][15:8] = wrData[7:0];
            2'd2: mD[b][wrSel[1:0]]       = wrData[15:0];
            default: begin
              mD[b][wrSel[1:0]]        = wrData[15:0];
              mD[b][{1'b1, wrSel[0]}]  = wrData[31:16];
            end
          endcase
        end
        4'd4: mA[b][0] = wrData[15:0];
        4'd5: mA[b][1] = wrData[15:0];
        4'd6: mFb[b]   = wrData[15:0];
        4'd7: if (mFlg[7]) mUsp = wrData[15:0]; else mIsp = wrData[15:0];
        4'd8: mSb = wrData[15:0];
        default: nf = wrData[15:0] & MASK;
      endcase
    end
    mFlg = nf;
  endtask

  task automatic modelReset();
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 4; i++) mD[b][i] = '0;
      for (int i = 0; i < 2; i++) mA[b][i] = '0;
      mFb[b] = '0;
    end
    mUsp = '0; mIsp = '0; mSb = '0; mFlg = '0;
  endtask

  task automatic check(input string req, input string port, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s port %s: got %h expected %h", req, port, got, exp);
    end
  endtask

  // One cycle: drive at negedge, check reads of pre-edge state, then the edge.
  task automatic step(input logic en, input logic [3:0] ws, input logic [1:0] wz,
                      input logic [31:0] wd, input logic fu, input logic [3:0] fbits,
                      input logic [3:0] sa, input logic [1:0] za,
                      input logic [3:0] sb, input logic [1:0] zb, input string tag);
    @(negedge clk);
    wrEn = en; wrSel = ws; wrSize = wz; wrData = wd;
    flagUpdEn = fu; {flagOvf, flagSign, flagZero, flagCarry} = fbits;
    rdSelA = sa; rdSizeA = za; rdSelB = sb; rdSizeB = zb;
    #1;
    check(tag == "" ? reqOf(sa, za) : tag, "A", rdDataA, expRead(sa, za));
    check(tag == "" ? reqOf(sb, zb) : tag, "B", rdDataB, expRead(sb, zb));
    @(posedge clk);
    modelWrite();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: every register clear after reset
    for (int s = 0; s < 10; s++) step(0, 0, 0, 0, 0, 0, 4'(s), 2'd2, 4'(s), 2'd2, "R9");

    // R2: byte writes keep the other byte
    step(1, 4'd0, 2'd2, 32'h0000_1234, 0, 0, 0, 2, 0, 2, "R2");
    step(1, 4'd0, 2'd1, 32'h0000_00AB, 0, 0, 0, 2, 0, 0, "R2");
    step(1, 4'd1, 2'd0, 32'h0000_00CD, 0, 0, 0, 2, 0, 1, "R2");
    step(0, 0, 0, 0, 0, 0, 4'd0, 2'd1, 4'd1, 2'd0, "R2");
    // R3: pair write both halves
    step(1, 4'd1, 2'd3, 32'hDEAD_BEEF, 0, 0, 4'd0, 2'd3, 4'd1, 2'd3, "R3");
    step(0, 0, 0, 0, 0, 0, 4'd1, 2'd3, 4'd3, 2'd2, "R3");
    // R1/R8: switch bank, next cycle sees bank 1
    step(1, 4'd9, 2'd2, 32'h0000_0010, 0, 0, 4'd0, 2'd2, 4'd9, 2'd2, "R8");
    step(1, 4'd4, 2'd2, 32'h0000_5555, 0, 0, 4'd0, 2'd2, 4'd1, 2'd3, "R8");
    step(1, 4'd9, 2'd2, 32'h0000_0000, 0, 0, 4'd4, 2'd2, 4'd0, 2'd2, "R1");
    step(0, 0, 0, 0, 0, 0, 4'd4, 2'd2, 4'd0, 2'd2, "R1");
    // R4: stack pointer selection
    step(1, 4'd7, 2'd2, 32'h0000_0AAA, 0, 0, 4'd7, 2'd2, 4'd7, 2'd2, "R4");
    step(1, 4'd9, 2'd2, 32'h0000_0080, 0, 0, 4'd7, 2'd2, 4'd7, 2'd2, "R4");
    step(1, 4'd7, 2'd2, 32'h0000_0BBB, 0, 0, 4'd7, 2'd2, 4'd9, 2'd2, "R4");
    step(1, 4'd9, 2'd2, 32'h0000_0000, 0, 0, 4'd7, 2'd2, 4'd7, 2'd2, "R4");
    step(0, 0, 0, 0, 0, 0, 4'd7, 2'd2, 4'd7, 2'd2, "R4");
    // R5: reserved bits dropped
    step(1, 4'd9, 2'd2, 32'h0000_FF4F, 0, 0, 4'd9, 2'd2, 4'd9, 2'd2, "R5");
    step(0, 0, 0, 0, 0, 0, 4'd9, 2'd2, 4'd9, 2'd1, "R5");
    // R10: flag update alone, then in conflict with a flag write
    step(0, 0, 0, 0, 1, 4'b1111, 4'd9, 2'd2, 4'd9, 2'd2, "R10");
    step(1, 4'd9, 2'd2, 32'h0000_0000, 1, 4'b1111, 4'd9, 2'd2, 4'd9, 2'd2, "R10");
    step(1, 4'd8, 2'd2, 32'h0000_7777, 1, 4'b0101, 4'd9, 2'd2, 4'd8, 2'd2, "R10");
    step(0, 0, 0, 0, 0, 0, 4'd9, 2'd2, 4'd8, 2'd2, "R10");
    // R7: illegal writes and reads
    step(1, 4'd4, 2'd3, 32'hFFFF_FFFF, 0, 0, 4'd4, 2'd2, 4'd2, 2'd2, "R7");
    step(1, 4'd2, 2'd0, 32'h0000_00FF, 0, 0, 4'd4, 2'd0, 4'd12, 2'd2, "R7");
    step(1, 4'd13, 2'd2, 32'h0000_FFFF, 0, 0, 4'd2, 2'd2, 4'd8, 2'd3, "R7");
    step(0, 0, 0, 0, 0, 0, 4'd2, 2'd2, 4'd4, 2'd2, "R7");
    // R6/R11: all selectors on both ports at once
    for (int s = 0; s < 10; s++) step(0, 0, 0, 0, 0, 0, 4'(s), 2'd2, 4'(9 - s), 2'd2, "R11");
    step(1, 4'd8, 2'd2, 32'hFFFF_9999, 0, 0, 4'd8, 2'd2, 4'd6, 2'd2, "R6");
    step(0, 0, 0, 0, 0, 0, 4'd8, 2'd2, 4'd8, 2'd0, "R6");

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] s, sa, sb;
      logic [1:0] z, za, zb;
      s  = 4'($urandom_range(0, 15)); z  = 2'($urandom);
      sa = 4'($urandom_range(0, 11)); za = 2'($urandom);
      sb = 4'($urandom_range(0, 11)); zb = 2'($urandom);
      if (($urandom % 3) == 0 && s <= 4'd9) z = 2'd2;
      step(1'($urandom), s, z, $urandom, ($urandom % 3) == 0, 4'($urandom),
           sa, za, sb, zb, "");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule